// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when the CPU clock of a small microcontroller core runs. It also decides when the oscillator may shut down and whether the watchdog keeps counting. Instruction decode supplies wait and stop requests. An interrupt request brings the core back. Two option bits, fixed at reset, shape the behaviour:

- The first option bit turns a stop request into a halt. Halt is a wait-like sleep: the oscillator and the watchdog keep running.
- The second option bit picks a short or a long recovery window for leaving halt.

An active-low reset places the block in a retention state. The CPU is frozen there for as long as reset stays low. When reset is released, the block runs a fixed reset sequence and then enters run.

The halt recovery delay comes from two free-running wrap counters. The short one has a period of 16 cycles and the long one a period of 4064 cycles. Both are cleared while reset is low and advance on every cycle after that. They are never restarted on halt entry. The CPU clock returns at the first terminal count of the selected counter after the wake. The delay therefore depends on the counter phase at the moment of the wake.

Top module: `lpm_sequencer`

## Requirements
- R1: On any rising edge that samples `rst_n` low, the block enters retention. From the next cycle, and for as long as `rst_n` stays low: `cpu_clk_en`=0, `wdog_en`=0, `osc_en`=1 and `mode`=00.
- R2: After the first rising edge that samples `rst_n` high, the block stays in its reset sequence for 4 cycles with `cpu_clk_en`=0. `cpu_clk_en` rises after the fifth such edge, with `mode`=00.
- R3: The option bits `opt_halt` and `opt_long_dly` are captured only on edges where `rst_n` is low. Changing them while `rst_n` is high has no effect until the next reset.
- R4: A `wait_req` (with `stop_req` low) in run gives, on the next cycle: `cpu_clk_en`=0, `osc_en`=1, `wdog_en`=1 and `mode`=01.
- R5: `irq` sampled in wait returns the block to run on the next cycle (`cpu_clk_en`=1, `mode`=00), with no delay.
- R6: A `stop_req` in run with the captured halt option clear gives full stop: `cpu_clk_en`=0, `osc_en`=0, `wdog_en`=0 and `mode`=11.
- R7: `irq` sampled in full stop returns the block to run on the next cycle, with `osc_en`=1 and `wdog_en`=1.
- R8: A `stop_req` in run with the captured halt option set gives halt: `cpu_clk_en`=0, `osc_en`=1, `wdog_en`=1 and `mode`=10.
- R9: With the captured delay option clear, leaving halt takes 1 to 16 cycles. Let w be the number of edges that sampled `rst_n` high, counted up to and including the edge that samples `irq` in halt. `cpu_clk_en` rises exactly d = ((15 - w mod 16) mod 16) + 1 edges after that edge. `mode` stays 10 until then.
- R10: With the captured delay option set, the same rule holds with period 4064: the delay is ((4063 - w mod 4064) mod 4064) + 1 cycles, between 1 and 4064.
- R11: While the halt option is selected, `wdog_en` stays 1 on every cycle of halt entry, halt residency and recovery.
- R12: Asserting `rst_n` low during a halt recovery aborts the recovery and gives the retention outputs of R1 on the next cycle.
- R13: When `stop_req` and `wait_req` arrive together in run, the stop request wins. Requests that arrive while the block is in wait, halt, recovery or stop are ignored, and `mode` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously; low means retention |
| wait_req | input | 1 | Wait request from instruction decode |
| stop_req | input | 1 | Stop request from instruction decode |
| irq | input | 1 | Pending enabled interrupt; wakes from any sleep state |
| opt_halt | input | 1 | One-time option: a stop request becomes halt |
| opt_long_dly | input | 1 | One-time option: long recovery range for halt exit |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| wdog_en | output | 1 | Watchdog count enable; low holds the watchdog |
| mode | output | 2 | Mode status: 00 run, 01 wait, 10 halt or recovery, 11 stop |

## Verification
The hardest case to reach from the ports is the halt exit. Its length depends on the phase of a counter that cannot be seen and that has been running since the last reset. Because that phase is hidden, a bound check alone would miss a counter that wraps early or restarts on halt entry.

The bench counts every edge since reset release, derives the counter phase from that count, and predicts the exact delay. It then drives random residency lengths and random resets in both ranges, so the wakes land on many different phases. These include the phases just before a terminal count, which give a one-cycle exit, and just after one, which give the full period. A directed case also pulls reset in the middle of a long recovery.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int DEF_SHORT_PERIOD = 16;
    localparam int DEF_LONG_PERIOD  = 4064;
    localparam int DEF_RST_CYCLES   = 4;

    typedef enum logic [2:0] {
        ST_RETAIN  = 3'd0,
        ST_RSTSEQ  = 3'd1,
        ST_RUN     = 3'd2,
        ST_WAIT    = 3'd3,
        ST_HALT    = 3'd4,
        ST_RECOVER = 3'd5,
        ST_STOP    = 3'd6
    } lpm_state_e;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_HALT = 2'b10,
        MODE_STOP = 2'b11
    } lpm_mode_e;

    typedef struct packed {
        logic halt_sel;
        logic long_dly;
    } lpm_opts_t;

    typedef struct packed {
        logic      cpu_clk_en;
        logic      osc_en;
        logic      wdog_en;
        lpm_mode_e mode;
    } lpm_ctrl_t;

    function automatic lpm_ctrl_t ctrl_of(lpm_state_e s);
        lpm_ctrl_t c;
        c.cpu_clk_en = 1'b0;
        c.osc_en     = 1'b1;
        c.wdog_en    = 1'b1;
        c.mode       = MODE_RUN;
        case (s)
            ST_RETAIN, ST_RSTSEQ: begin
                c.wdog_en = 1'b0;
            end
            ST_RUN: begin
                c.cpu_clk_en = 1'b1;
            end
            ST_WAIT: begin
                c.mode = MODE_WAIT;
            end
            ST_HALT, ST_RECOVER: begin
                c.mode = MODE_HALT;
            end
            ST_STOP: begin
                c.osc_en  = 1'b0;
                c.wdog_en = 1'b0;
                c.mode    = MODE_STOP;
            end
            default: begin
                c.wdog_en = 1'b0;
            end
        endcase
        return c;
    endfunction

    function automatic lpm_state_e sleep_target(lpm_opts_t o);
        return o.halt_sel ? ST_HALT : ST_STOP;
    endfunction

endpackage

// File: rtl/lpm_opt_latch.sv
module lpm_opt_latch
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      opt_halt,
    input  logic      opt_long_dly,
    output lpm_opts_t opts
);

    lpm_opts_t opts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opts_q.halt_sel <= opt_halt;
            opts_q.long_dly <= opt_long_dly;
        end
    end

    assign opts = opts_q;

    // Options may only move on edges where reset is held
    assert_opt_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(opts_q));

endmodule

// File: rtl/lpm_wrap_counter.sv
module lpm_wrap_counter #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tc
);

    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tc = (cnt == LAST);

    // After a terminal count the phase restarts from zero
    assert_wrap_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (cnt == '0));

endmodule

// File: rtl/lpm_prescaler.sv
module lpm_prescaler
    import lpm_pkg::*;
#(
    parameter int SHORT_PERIOD = DEF_SHORT_PERIOD,
    parameter int LONG_PERIOD  = DEF_LONG_PERIOD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic long_sel,
    output logic tc
);

    localparam int NUM_RANGES = 2;

    logic [NUM_RANGES-1:0] tc_v;

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_range
        localparam int P = (g == 0) ? SHORT_PERIOD : LONG_PERIOD;
        lpm_wrap_counter #(.PERIOD(P)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .tc    (tc_v[g])
        );
    end

    assign tc = long_sel ? tc_v[1] : tc_v[0];

    // Short range terminal count never repeats on adjacent cycles
    assert_short_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tc_v[0] |=> !tc_v[0]);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
#(
    parameter int RST_CYCLES = DEF_RST_CYCLES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wait_req,
    input  logic       stop_req,
    input  logic       irq,
    input  lpm_opts_t  opts,
    input  logic       tc,
    output lpm_state_e state,
    output lpm_ctrl_t  ctrl
);

    localparam int SEQ_W = $clog2(RST_CYCLES + 1);
    localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(RST_CYCLES - 1);

    lpm_state_e       state_q, state_d;
    logic [SEQ_W-1:0] seq_q, seq_d;

    always_comb begin
        state_d = state_q;
        seq_d   = seq_q;
        case (state_q)
            ST_RETAIN: begin
                state_d = ST_RSTSEQ;
                seq_d   = '0;
            end
            ST_RSTSEQ: begin
                if (seq_q == SEQ_LAST) begin
                    state_d = ST_RUN;
                end else begin
                    seq_d = seq_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (stop_req) begin
                    state_d = sleep_target(opts);
                end else if (wait_req) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT, ST_STOP: begin
                if (irq) state_d = ST_RUN;
            end
            ST_HALT: begin
                if (irq) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (tc) state_d = ST_RUN;
            end
            default: begin
                state_d = ST_RETAIN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RETAIN;
            seq_q   <= '0;
        end else begin
            state_q <= state_d;
            seq_q   <= seq_d;
        end
    end

    assign state = state_q;
    assign ctrl  = ctrl_of(state_q);

    assert_retain_entry_R1: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_RETAIN && !ctrl.cpu_clk_en && !ctrl.wdog_en));

    assert_rstseq_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RSTSEQ && seq_q != SEQ_LAST) |=> (state_q == ST_RSTSEQ));

    assert_wait_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wait_req && !stop_req) |=>
            (ctrl.mode == MODE_WAIT && !ctrl.cpu_clk_en));

    assert_wait_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && irq) |=> ctrl.cpu_clk_en);

    assert_full_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_req && !opts.halt_sel) |=> (!ctrl.osc_en && !ctrl.wdog_en));

    assert_stop_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && irq) |=> (ctrl.osc_en && ctrl.cpu_clk_en));

    assert_halt_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_req && opts.halt_sel) |=> ctrl.wdog_en);

    assert_halt_stay_wdog_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_HALT, ST_RECOVER}) |=> ctrl.wdog_en);

    assert_recover_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER && !tc) |=> (state_q == ST_RECOVER));

    assert_recover_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER && tc) |=> ctrl.cpu_clk_en);

    assert_wait_ignores_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !irq) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int SHORT_PERIOD = DEF_SHORT_PERIOD,
    parameter int LONG_PERIOD  = DEF_LONG_PERIOD,
    parameter int RST_CYCLES   = DEF_RST_CYCLES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wait_req,
    input  logic       stop_req,
    input  logic       irq,
    input  logic       opt_halt,
    input  logic       opt_long_dly,
    output logic       cpu_clk_en,
    output logic       osc_en,
    output logic       wdog_en,
    output logic [1:0] mode
);

    lpm_opts_t  opts;
    logic       tc;
    lpm_state_e state;
    lpm_ctrl_t  ctrl;

    lpm_opt_latch u_opts (
        .clk          (clk),
        .rst_n        (rst_n),
        .opt_halt     (opt_halt),
        .opt_long_dly (opt_long_dly),
        .opts         (opts)
    );

    lpm_prescaler #(
        .SHORT_PERIOD (SHORT_PERIOD),
        .LONG_PERIOD  (LONG_PERIOD)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .long_sel (opts.long_dly),
        .tc       (tc)
    );

    lpm_fsm #(
        .RST_CYCLES (RST_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_req (wait_req),
        .stop_req (stop_req),
        .irq      (irq),
        .opts     (opts),
        .tc       (tc),
        .state    (state),
        .ctrl     (ctrl)
    );

    assign cpu_clk_en = ctrl.cpu_clk_en;
    assign osc_en     = ctrl.osc_en;
    assign wdog_en    = ctrl.wdog_en;
    assign mode       = ctrl.mode;

    // An oscillator shutdown must always come with a held watchdog
    assert_osc_off_wdog_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!wdog_en && mode == 2'b11 && state == ST_STOP));

endmodule

// File: tb/lpm_sequencer_test.sv
module lpm_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int SHORT_P    = 16;
    localparam int LONG_P     = 4064;
    localparam int RST_CYC    = 4;
    localparam int WDOG_LIMIT = 190000;

    logic       clk;
    logic       rst_n;
    logic       wait_req, stop_req, irq;
    logic       opt_halt, opt_long_dly;
    logic       cpu_clk_en, osc_en, wdog_en;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    int bcnt   = 0;
    bit cur_halt = 1'b0;
    bit cur_long = 1'b0;

    lpm_sequencer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wait_req     (wait_req),
        .stop_req     (stop_req),
        .irq          (irq),
        .opt_halt     (opt_halt),
        .opt_long_dly (opt_long_dly),
        .cpu_clk_en   (cpu_clk_en),
        .osc_en       (osc_en),
        .wdog_en      (wdog_en),
        .mode         (mode)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Edges sampled with reset high since the last reset (phase model of R9/R10)
    always @(posedge clk) begin
        if (!rst_n) bcnt <= 0;
        else        bcnt <= bcnt + 1;
    end

    function automatic int exp_delay(int w, bit lng);
        int p;
        p = lng ? LONG_P : SHORT_P;
        return ((p - 1 - (w % p)) % p) + 1;
    endfunction

    function automatic int exp_sleep_mode(bit halt);
        return halt ? 2 : 3;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_out(string req, int cpu, int osc, int wd, int md);
        chk({req, " cpu_clk_en"}, int'(cpu_clk_en), cpu);
        chk({req, " osc_en"},     int'(osc_en),     osc);
        chk({req, " wdog_en"},    int'(wdog_en),    wd);
        chk({req, " mode"},       int'(mode),       md);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(bit h, bit l, string tag);
        rst_n = 1'b0; opt_halt = h; opt_long_dly = l;
        wait_req = 1'b0; stop_req = 1'b0; irq = 1'b0;
        tick();
        chk_out(tag, 0, 1, 0, 0);
        tick(); tick();
        chk_out("R1 held", 0, 1, 0, 0);
        cur_halt = h; cur_long = l;
        rst_n = 1'b1;
        for (int k = 1; k <= RST_CYC; k++) begin
            tick();
            chk("R2 sequence", int'(cpu_clk_en), 0);
        end
        tick();
        chk_out("R2 run", 1, 1, 1, 0);
    endtask

    task automatic do_wait(int stay);
        wait_req = 1'b1;
        tick();
        wait_req = 1'b0;
        chk_out("R4", 0, 1, 1, 1);
        for (int i = 0; i < stay; i++) begin
            stop_req = 1'b1; wait_req = (i % 2) == 0;
            tick();
            stop_req = 1'b0; wait_req = 1'b0;
            chk("R13 wait ignores req", int'(mode), 1);
        end
        irq = 1'b1;
        tick();
        irq = 1'b0;
        chk_out("R5", 1, 1, 1, 0);
    endtask

    task automatic sleep_wake(int stay);
        int w, exp, j;
        for (int i = 0; i < stay; i++) begin
            wait_req = 1'b1; stop_req = (i % 2) == 1;
            tick();
            wait_req = 1'b0; stop_req = 1'b0;
            chk("R13 sleep ignores req", int'(mode), exp_sleep_mode(cur_halt));
            if (cur_halt) chk("R11 residency", int'(wdog_en), 1);
        end
        irq = 1'b1;
        tick();
        irq = 1'b0;
        w = bcnt;
        if (!cur_halt) begin
            chk_out("R7", 1, 1, 1, 0);
        end else begin
            exp = exp_delay(w, cur_long);
            chk_out("R11 recovery start", 0, 1, 1, 2);
            j = 0;
            do begin
                tick();
                j++;
                if (!cpu_clk_en) chk("R9 recovery mode", int'(mode), 2);
                chk("R11 recovery", int'(wdog_en), 1);
            end while (!cpu_clk_en && j < LONG_P + 2);
            if (cur_long) begin
                chk("R10 delay", j, exp);
                chk("R10 bound", int'(j >= 1 && j <= LONG_P), 1);
            end else begin
                chk("R9 delay", j, exp);
                chk("R9 bound", int'(j >= 1 && j <= SHORT_P), 1);
            end
            chk("R9 back to run", int'(mode), 0);
        end
    endtask

    task automatic do_stop(int stay);
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
        if (cur_halt) chk_out("R8", 0, 1, 1, 2);
        else          chk_out("R6", 0, 0, 0, 3);
        sleep_wake(stay);
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        int unsigned r;
        seed_init = $urandom(32'd91357);
        rst_n = 1'b0; wait_req = 1'b0; stop_req = 1'b0; irq = 1'b0;
        opt_halt = 1'b0; opt_long_dly = 1'b0;

        // Reset state and plain wait / full stop
        do_reset(1'b0, 1'b0, "R1");
        do_wait(0);
        do_wait(3);
        do_stop(2);

        // R3: options changed after reset are ignored
        opt_halt = 1'b1; opt_long_dly = 1'b1;
        tick();
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
        chk("R3 option frozen", int'(mode), 3);
        sleep_wake(1);

        // R13: simultaneous requests, stop wins
        do_reset(1'b1, 1'b0, "R1");
        wait_req = 1'b1; stop_req = 1'b1;
        tick();
        wait_req = 1'b0; stop_req = 1'b0;
        chk("R13 stop priority", int'(mode), 2);
        sleep_wake(0);

        // Short-range halt at several phases
        for (int i = 0; i < 17; i++) do_stop(i % 5);

        // Long-range halt
        do_reset(1'b1, 1'b1, "R1");
        do_stop(0);
        do_stop(7);

        // R12: reset during recovery
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
        irq = 1'b1;
        tick();
        irq = 1'b0;
        repeat (5) tick();
        chk("R12 still recovering", int'(mode), 2);
        do_reset(1'b1, 1'b0, "R12");

        // Constrained random mix
        for (int it = 0; it < 30; it++) begin
            r = $urandom % 8;
            if (r == 0)      do_reset(1'($urandom % 2), 1'(($urandom % 4) == 0), "R1");
            else if (r < 3)  do_wait(int'($urandom % 6));
            else             do_stop(int'($urandom % 6));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule